// File: doc/BRIEF.md
# Pixel Format Packing Unit

This block sits between a pixel capture pipeline and a frame-buffer writer. It accepts one pixel per handshake on a valid/ready input and turns the stream into 32-bit memory words on a valid/ready output. In colour mode each 24-bit red/green/blue pixel is narrowed to a 16-bit 5:6:5 value by dropping low-order bits, and two such values share one word. In grayscale mode 12-bit samples are left-justified in 16-bit halves, packed either two per word or one per word.

A start-of-frame flag on the input throws away any half-filled word left from the previous frame. An end-of-frame flag on a pixel that would open a new word makes the unit emit that word at once, with its lower half zero. When the consumer stalls, the output word is held and no new pixel is taken.

Top module: `pix_pack_top`

## Requirements
- R1: After reset `out_valid` is 0, `out_word` is 0 and `in_ready` is 1.
- R2: In colour mode (`fmt_gray`=0) a pixel with red in `in_data[23:16]`, green in `in_data[15:8]` and blue in `in_data[7:0]` becomes the 16-bit value {red[7:3], green[7:2], blue[7:3]}, with no rounding.
- R3: In colour mode two converted pixels form one word; the pixel taken first occupies `out_word[31:16]`, the second `out_word[15:0]`.
- R4: In grayscale two-per-word mode (`fmt_gray`=1, `gray_single`=0) the sample is `in_data[11:0]`; the word is {first[11:0], 4'b0000, second[11:0], 4'b0000}.
- R5: In grayscale one-per-word mode (`fmt_gray`=1, `gray_single`=1) every pixel emits its own word {sample[11:0], 4'b0000, 16'h0000}; `gray_single` has no effect in colour mode.
- R6: A pixel flagged `in_eof` that would fill the upper half of a word in a two-per-word mode is emitted at once with the lower 16 bits zero.
- R7: A pixel flagged `in_sof` always starts a new word; a half-filled word held from before is discarded and never emitted.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_word` and `out_valid` hold and `in_ready` is 0.
- R9: A word appears on the output only as a result of accepted pixels; `in_data` has no effect while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_gray | input | 1 | 1 = grayscale samples, 0 = 8:8:8 colour |
| gray_single | input | 1 | In grayscale, 1 = one pixel per word, 0 = two |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Unit can take a pixel this cycle |
| in_data | input | 24 | Pixel: colour channels or 12-bit sample in bits 11:0 |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eof | input | 1 | Pixel is the last of a frame |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 32 | Packed memory word |

## Verification
The checker watches, on every cycle, that a stalled word stays put with the input closed, that new words only follow an accepted pixel, that grayscale words always carry zero padding nibbles, and that one-per-word words have a zero lower half. Exact bit placement of the narrowed colour channels, the order of the two halves, the dropping of a stale half at a new frame and the zero-padded final word of an odd frame depend on data values and pixel history, so only the bench's sweeps and frame scenarios show them.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;

  typedef enum logic [1:0] {
    FMT_RGB   = 2'd0,
    FMT_GRAY2 = 2'd1,
    FMT_GRAY1 = 2'd2
  } fmt_sel_e;

  function automatic fmt_sel_e decode_fmt(input logic gray, input logic single);
    if (!gray)       return FMT_RGB;
    else if (single) return FMT_GRAY1;
    else             return FMT_GRAY2;
  endfunction

endpackage

// File: rtl/pix_fmt_cvt.sv
module pix_fmt_cvt
  import pix_pack_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int R_W    = 5,
  parameter int G_W    = 6,
  parameter int B_W    = 5,
  parameter int GRAY_W = 12,
  parameter int HALF_W = 16
) (
  input  fmt_sel_e              sel,
  input  logic [3*CH_W-1:0]     pix,
  output logic [HALF_W-1:0]     half
);

  localparam int IN_W    = 3 * CH_W;
  localparam int PAD_W   = HALF_W - GRAY_W;
  localparam int R_HI    = IN_W - 1;
  localparam int G_HI    = 2 * CH_W - 1;
  localparam int B_HI    = CH_W - 1;

  logic [R_W-1:0]    red_n;
  logic [G_W-1:0]    grn_n;
  logic [B_W-1:0]    blu_n;
  logic [HALF_W-1:0] rgb_half;
  logic [HALF_W-1:0] gray_half;

  // keep the most significant bits of each channel, drop the rest
  assign red_n    = pix[R_HI -: R_W];
  assign grn_n    = pix[G_HI -: G_W];
  assign blu_n    = pix[B_HI -: B_W];
  assign rgb_half = {red_n, grn_n, blu_n};

  generate
    if (PAD_W > 0) begin : g_pad
      assign gray_half = {pix[GRAY_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign gray_half = pix[GRAY_W-1 -: HALF_W];
    end
  endgenerate

  always_comb begin
    if (sel == FMT_RGB) half = rgb_half;
    else                half = gray_half;
  end

endmodule

// File: rtl/pix_word_asm.sv
module pix_word_asm
  import pix_pack_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fmt_sel_e              sel,
  input  logic                  take,
  input  logic [HALF_W-1:0]     half,
  input  logic                  sof,
  input  logic                  eof,
  input  logic                  drain,
  output logic                  word_vld,
  output logic [2*HALF_W-1:0]   word
);

  localparam int WORD_W = 2 * HALF_W;

  logic              have_q;
  logic [HALF_W-1:0] pend_q;
  logic              opens_word;

  assign opens_word = sof || !have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q   <= 1'b0;
      pend_q   <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      if (word_vld && drain) word_vld <= 1'b0;
      if (take) begin
        if (sel == FMT_GRAY1) begin
          word     <= {half, {HALF_W{1'b0}}};
          word_vld <= 1'b1;
          have_q   <= 1'b0;
        end else if (opens_word) begin
          if (eof) begin
            word     <= {half, {HALF_W{1'b0}}};
            word_vld <= 1'b1;
            have_q   <= 1'b0;
          end else begin
            pend_q   <= half;
            have_q   <= 1'b1;
          end
        end else begin
          word     <= {pend_q, half};
          word_vld <= 1'b1;
          have_q   <= 1'b0;
        end
      end
    end
  end

  initial begin
    if (WORD_W != 2 * HALF_W) $error("word width mismatch");
  end

endmodule

// File: rtl/pix_pack_top.sv
module pix_pack_top
  import pix_pack_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int R_W    = 5,
  parameter int G_W    = 6,
  parameter int B_W    = 5,
  parameter int GRAY_W = 12,
  parameter int HALF_W = 16,
  localparam int IN_W   = 3 * CH_W,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_gray,
  input  logic              gray_single,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);

  fmt_sel_e          sel;
  logic [HALF_W-1:0] half;
  logic              take;

  assign sel      = decode_fmt(fmt_gray, gray_single);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  pix_fmt_cvt #(
    .CH_W(CH_W), .R_W(R_W), .G_W(G_W), .B_W(B_W),
    .GRAY_W(GRAY_W), .HALF_W(HALF_W)
  ) u_cvt (
    .sel  (sel),
    .pix  (in_data),
    .half (half)
  );

  pix_word_asm #(
    .HALF_W(HALF_W)
  ) u_asm (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .take     (take),
    .half     (half),
    .sof      (in_sof),
    .eof      (in_eof),
    .drain    (out_ready),
    .word_vld (out_valid),
    .word     (out_word)
  );

endmodule

// File: rtl/pix_pack_chk.sv
module pix_pack_chk #(
  parameter int IN_W   = 24,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fmt_gray,
  input logic              gray_single,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IN_W-1:0]   in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);

  localparam int HW = WORD_W / 2;

  logic acc;
  assign acc = in_valid && in_ready;

  // R8: stalled word holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R8: input closed during stall
  p_stall_closed_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: a new word only after an accepted pixel
  p_word_needs_pixel_r9: assert property (@(posedge clk) disable iff (rst)
    (!acc && !(out_valid && !out_ready)) |=> !out_valid);

  // R5: single grayscale word has empty lower half
  p_single_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && fmt_gray && gray_single) |=> (out_valid && out_word[HW-1:0] == '0));

  // R4: grayscale padding nibbles are zero
  p_gray_pad_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fmt_gray) |-> (out_word[HW+3:HW] == 4'h0 && out_word[3:0] == 4'h0));

endmodule

bind pix_pack_top pix_pack_chk #(.IN_W(IN_W), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fmt_gray    (fmt_gray),
  .gray_single (gray_single),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_word    (out_word)
);

// File: tb/pix_pack_top_bench.sv
`timescale 1ns/1ps
module pix_pack_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_gray = 1'b0;
  logic        gray_single = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pix_pack_top u_pix_pack_top (
    .clk(clk), .rst(rst), .fmt_gray(fmt_gray), .gray_single(gray_single),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  function automatic logic [15:0] rgb565(input logic [23:0] p);
    return {p[23:19], p[15:10], p[7:3]};
  endfunction

  function automatic logic [15:0] gray16(input logic [11:0] g);
    return {g, 4'h0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [31:0] exp);
    check(out_valid && out_word == exp, req, out_word, exp);
  endtask

  task automatic check_idle(input string req);
    check(!out_valid, req, {31'd0, out_valid}, 32'd0);
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic push(input logic [23:0] d, input bit sof, input bit eof);
    bit rdy;
    in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof;
    rdy = in_ready;
    @(posedge clk);
    while (!rdy) begin
      @(negedge clk);
      rdy = in_ready;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    logic [23:0] a, b;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!out_valid && out_word == 32'd0 && in_ready, "R1", out_word, 32'd0);

    // R2 / R3 colour sweep
    fmt_gray = 1'b0; gray_single = 1'b0;
    for (int v = 0; v < 256; v++) begin
      a = {v[7:0], ~v[7:0], v[7:0] ^ 8'hA5};
      b = {~v[7:0], v[7:0], v[7:0] + 8'd37};
      push(a, v == 0, 1'b0);
      check_idle("R3 half word not emitted");
      push(b, 1'b0, 1'b0);
      check_word("R2/R3 colour word", {rgb565(a), rgb565(b)});
    end
    // R5: gray_single ignored in colour mode
    gray_single = 1'b1;
    push(24'hFFFFFF, 1'b1, 1'b0);
    check_idle("R5 single ignored in colour");
    push(24'h081020, 1'b0, 1'b0);
    check_word("R5 single ignored in colour", {16'hFFFF, rgb565(24'h081020)});
    @(negedge clk);

    // R4 grayscale two per word, all samples
    fmt_gray = 1'b1; gray_single = 1'b0;
    for (int s = 0; s < 4096; s += 2) begin
      push({12'hABC, s[11:0]}, s == 0, 1'b0);
      push({12'h123, s[11:0] + 12'd1}, 1'b0, 1'b0);
      check_word("R4 gray pair", {gray16(s[11:0]), gray16(s[11:0] + 12'd1)});
    end
    @(negedge clk);

    // R5 grayscale one per word
    gray_single = 1'b1;
    for (int s = 0; s < 4096; s += 7) begin
      push({12'hFFF, s[11:0]}, s == 0, 1'b0);
      check_word("R5 gray single", {gray16(s[11:0]), 16'h0000});
    end
    @(negedge clk);

    // R6 odd frame end, colour and gray
    gray_single = 1'b0;
    push(24'h000ABC, 1'b1, 1'b0);
    push(24'h000DEF, 1'b0, 1'b0);
    check_word("R6 pair before odd end", {gray16(12'hABC), gray16(12'hDEF)});
    push(24'h000777, 1'b0, 1'b1);
    check_word("R6 odd tail gray", {gray16(12'h777), 16'h0000});
    @(negedge clk);
    fmt_gray = 1'b0;
    push(24'hF0E0D0, 1'b1, 1'b1);
    check_word("R6 odd tail colour", {rgb565(24'hF0E0D0), 16'h0000});
    @(negedge clk);

    // R7 start of frame drops half word
    push(24'h112233, 1'b1, 1'b0);
    push(24'h445566, 1'b1, 1'b0);
    check_idle("R7 stale half dropped");
    push(24'h778899, 1'b0, 1'b0);
    check_word("R7 new frame word", {rgb565(24'h445566), rgb565(24'h778899)});
    @(negedge clk);

    // R9 data ignored without valid
    for (int k = 0; k < 6; k++) begin
      in_data = 24'h5A5A5A ^ k;
      @(negedge clk);
      check_idle("R9 no word without valid");
    end
    push(24'h010203, 1'b0, 1'b0);
    push(24'h040506, 1'b0, 1'b0);
    check_word("R9 only accepted pixels", {rgb565(24'h010203), rgb565(24'h040506)});
    @(negedge clk);

    // R8 backpressure
    out_ready = 1'b0;
    push(24'hFF0000, 1'b1, 1'b0);
    push(24'h00FF00, 1'b0, 1'b0);
    w = {rgb565(24'hFF0000), rgb565(24'h00FF00)};
    check_word("R8 stalled word", w);
    in_valid = 1'b1; in_data = 24'h0000FF;
    for (int k = 0; k < 4; k++) begin
      check(!in_ready, "R8 input closed", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      check_word("R8 word held", w);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_idle("R8 drained");
    push(24'h808080, 1'b0, 1'b0);
    check_word("R8 after release", {rgb565(24'h0000FF), rgb565(24'h808080)});
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule